// File: doc/BRIEF.md
# Transfer Length Controller for a Storage-Bus DMA Engine

This block decides how many bytes a transfer-information step moves and tracks that length while the device side hands over buffers. When a start pulse arrives, it reads a 16-bit count from two byte-wide counter registers. A count of zero stands for the largest possible transfer. The block then clamps the count against one of two limits. In the command phase the limit is a fixed command cap. In the data phase the limit is the magnitude of the signed residual the target reported, and the sign of that residual also gives the direction of the transfer.

After the load, the block grants chunks. Each chunk is the smaller of the remaining length and the buffer length the device offers. Each grant lowers the remaining length and moves the residual. Completion comes in one of two ways. It is immediate when a device buffer is left partly used, or when a read has consumed its length while the residual is still positive. In every other case completion waits for the next buffer event from the device. When it completes, the block pulses `done`, which the surrounding register file uses to clear its counter, sequence and flag registers. One cycle later the block sets the terminal-count status, the interrupt line and the bus-service interrupt code. Memory access itself is handled elsewhere.

The controller is a five-state machine:
- IDLE waits for `start`.
- CMD_GRANT hands the whole command length over in one cycle.
- WAIT_DATA grants chunks against device buffers.
- DEFER holds a completion until the next buffer event.
- FINISH issues the completion strobe.

The transitions are:
- IDLE→CMD_GRANT on a start in the command phase.
- IDLE→WAIT_DATA on a start in the data phase.
- CMD_GRANT→FINISH unconditionally.
- WAIT_DATA→FINISH on a partial buffer or a satisfied read.
- WAIT_DATA→WAIT_DATA while length remains after a fully used buffer.
- WAIT_DATA→DEFER when the length runs out without a completion condition.
- DEFER→FINISH on the next buffer event.
- FINISH→IDLE unconditionally.

Top module: `xfer_len_ctrl`

## Requirements
- R1: On a start pulse the count is `{cnt_mid, cnt_lo}`, and a count of 0 is taken as 65536. `remaining` shows the loaded length in the cycle after the start.
- R2: In the command phase (`cmd_phase`=1 at the start) the length is min(count, 32). The whole length is granted as a single chunk in the cycle after the start, `done` pulses one cycle later, and `resid_out` is zeroed.
- R3: In the data phase the length is min(count, |`resid_in`|). A negative `resid_in` marks a transfer toward the device, and zero or positive marks a transfer from the device.
- R4: A start clears `tc`, `irq` and `int_code` before any chunk is granted. A start that arrives while `busy` is 1 is ignored and leaves `remaining` and `resid_out` unchanged.
- R5: While `avail_valid` is 1 in the data phase, the granted `chunk_len` is min(`remaining`, `avail_len`) and `remaining` drops by that amount. `resid_out` rises by the chunk toward the device and falls by it from the device.
- R6: If a chunk is smaller than `avail_len` (buffer partly used), `done` pulses in the next cycle.
- R7: For a transfer from the device, if a chunk brings `remaining` to 0 while the new residual is positive, `done` pulses in the next cycle. Any other exhausted length waits, with `done` low, until the next `avail_valid`, and `done` pulses the cycle after that event.
- R8: While busy and waiting without `avail_valid`, `remaining` and `resid_out` hold their values and no chunk is granted.
- R9: `done` is a one-cycle strobe; it also orders the counter, sequence and flag registers cleared. In the cycle after it, `tc`=1, `irq`=1, `int_code`=0x10 (bus service), and `busy`=0.
- R10: A synchronous reset gives `busy`=0, `remaining`=0, `resid_out`=0, `tc`=0, `irq`=0, `int_code`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer-information step |
| cmd_phase | input | 1 | Step belongs to the command phase |
| cnt_lo | input | 8 | Low byte of the programmed count |
| cnt_mid | input | 8 | Mid byte of the programmed count |
| resid_in | input | 18 | Signed residual size from the target |
| avail_valid | input | 1 | Device offers a buffer this cycle |
| avail_len | input | 17 | Length of the offered buffer |
| busy | output | 1 | A step is in progress |
| chunk_valid | output | 1 | A chunk is granted this cycle |
| chunk_len | output | 17 | Length of the granted chunk |
| remaining | output | 17 | Length still to move |
| resid_out | output | 18 | Tracked signed residual |
| tc | output | 1 | Terminal-count status |
| done | output | 1 | Completion strobe and register-clear order |
| irq | output | 1 | Interrupt line |
| int_code | output | 8 | Interrupt code register |

## Verification
The bench builds the block with its default parameters: 8-bit count bytes, an 18-bit residual, 17-bit buffer lengths and a command cap of 32. These widths make the full 65536 length reachable, both from a zero count and from a maximal count of 65535. They also make residuals larger than any count reachable, so the count wins the clamp, and negative residuals reachable in the write direction. Directed scenarios drive each completion path: partial buffer, satisfied read, and deferred completion in both directions. They also cover a zero-length clamp, the command cap, and starts that arrive while a step is running.

// File: rtl/xfer_len_pkg.sv
package xfer_len_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_GRANT,
        ST_WAIT_DATA,
        ST_DEFER,
        ST_FINISH
    } xfer_state_t;

    localparam logic [7:0] INT_BUS_SERVICE = 8'h10;

endpackage

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
    parameter int BYTE_W  = 8,
    parameter int RES_W   = 18,
    parameter int CMD_CAP = 32
) (
    input  logic [BYTE_W-1:0]        cnt_lo,
    input  logic [BYTE_W-1:0]        cnt_mid,
    input  logic                     cmd_phase,
    input  logic signed [RES_W-1:0]  resid_in,
    output logic [2*BYTE_W:0]        len,
    output logic                     to_dev
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam int LEN_W = CNT_W + 1;
    localparam int CMP_W = (LEN_W > RES_W) ? LEN_W : RES_W;

    logic [CNT_W-1:0] raw;
    logic [LEN_W-1:0] count;
    logic [RES_W-1:0] res_u;
    logic [RES_W-1:0] mag;
    logic [CMP_W-1:0] cap_e;
    logic [CMP_W-1:0] cnt_e;
    logic [CMP_W-1:0] len_e;

    always_comb begin
        raw    = {cnt_mid, cnt_lo};
        count  = (raw == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, raw};
        res_u  = resid_in;
        to_dev = res_u[RES_W-1];
        mag    = to_dev ? ({RES_W{1'b0}} - res_u) : res_u;
        cnt_e  = CMP_W'(count);
        cap_e  = cmd_phase ? CMP_W'(CMD_CAP) : CMP_W'(mag);
        len_e  = (cnt_e < cap_e) ? cnt_e : cap_e;
        len    = LEN_W'(len_e);
    end
endmodule

// File: rtl/xfer_chunk_step.sv
module xfer_chunk_step #(
    parameter int LEN_W = 17,
    parameter int RES_W = 18,
    parameter int AVL_W = 17
) (
    input  logic [LEN_W-1:0]        remaining,
    input  logic signed [RES_W-1:0] resid,
    input  logic                    to_dev,
    input  logic [AVL_W-1:0]        avail_len,
    output logic [LEN_W-1:0]        chunk,
    output logic [LEN_W-1:0]        rem_next,
    output logic signed [RES_W-1:0] resid_next,
    output logic                    partial,
    output logic                    rem_empty,
    output logic                    read_done
);
    localparam int CW = (LEN_W > AVL_W) ? LEN_W : AVL_W;

    logic [CW-1:0]           rem_e;
    logic [CW-1:0]           av_e;
    logic [CW-1:0]           chunk_e;
    logic signed [RES_W-1:0] chunk_s;

    always_comb begin
        rem_e      = CW'(remaining);
        av_e       = CW'(avail_len);
        chunk_e    = (rem_e < av_e) ? rem_e : av_e;
        chunk      = LEN_W'(chunk_e);
        partial    = chunk_e < av_e;
        rem_next   = remaining - chunk;
        rem_empty  = (rem_next == '0);
        chunk_s    = signed'(RES_W'(chunk));
        resid_next = to_dev ? (resid + chunk_s) : (resid - chunk_s);
        read_done  = !to_dev && rem_empty &&
                     !resid_next[RES_W-1] && (resid_next != '0);
    end
endmodule

// File: rtl/xfer_len_ctrl.sv
module xfer_len_ctrl
    import xfer_len_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int RES_W   = 18,
    parameter int AVL_W   = 17,
    parameter int CMD_CAP = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cmd_phase,
    input  logic [BYTE_W-1:0]       cnt_lo,
    input  logic [BYTE_W-1:0]       cnt_mid,
    input  logic signed [RES_W-1:0] resid_in,
    input  logic                    avail_valid,
    input  logic [AVL_W-1:0]        avail_len,
    output logic                    busy,
    output logic                    chunk_valid,
    output logic [2*BYTE_W:0]       chunk_len,
    output logic [2*BYTE_W:0]       remaining,
    output logic signed [RES_W-1:0] resid_out,
    output logic                    tc,
    output logic                    done,
    output logic                    irq,
    output logic [7:0]              int_code
);
    localparam int LEN_W = 2 * BYTE_W + 1;

    xfer_state_t state_q, state_d;

    logic [LEN_W-1:0]        load_len;
    logic                    load_to_dev;
    logic                    to_dev_q;
    logic [LEN_W-1:0]        step_chunk;
    logic [LEN_W-1:0]        step_rem;
    logic signed [RES_W-1:0] step_resid;
    logic                    step_partial;
    logic                    step_empty;
    logic                    step_read_done;

    xfer_len_calc #(
        .BYTE_W (BYTE_W),
        .RES_W  (RES_W),
        .CMD_CAP(CMD_CAP)
    ) u_calc (
        .cnt_lo   (cnt_lo),
        .cnt_mid  (cnt_mid),
        .cmd_phase(cmd_phase),
        .resid_in (resid_in),
        .len      (load_len),
        .to_dev   (load_to_dev)
    );

    xfer_chunk_step #(
        .LEN_W(LEN_W),
        .RES_W(RES_W),
        .AVL_W(AVL_W)
    ) u_step (
        .remaining (remaining),
        .resid     (resid_out),
        .to_dev    (to_dev_q),
        .avail_len (avail_len),
        .chunk     (step_chunk),
        .rem_next  (step_rem),
        .resid_next(step_resid),
        .partial   (step_partial),
        .rem_empty (step_empty),
        .read_done (step_read_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = cmd_phase ? ST_CMD_GRANT : ST_WAIT_DATA;
            end
            ST_CMD_GRANT: state_d = ST_FINISH;
            ST_WAIT_DATA: begin
                if (avail_valid) begin
                    if (step_partial || step_read_done) state_d = ST_FINISH;
                    else if (!step_empty)               state_d = ST_WAIT_DATA;
                    else                                state_d = ST_DEFER;
                end
            end
            ST_DEFER: begin
                if (avail_valid) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy        = 1'b1;
        chunk_valid = 1'b0;
        chunk_len   = '0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_CMD_GRANT: begin
                chunk_valid = 1'b1;
                chunk_len   = remaining;
            end
            ST_WAIT_DATA: begin
                chunk_valid = avail_valid;
                chunk_len   = avail_valid ? step_chunk : '0;
            end
            ST_DEFER:  ;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // length, residual and status registers
    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            resid_out <= '0;
            to_dev_q  <= 1'b0;
            tc        <= 1'b0;
            irq       <= 1'b0;
            int_code  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        remaining <= load_len;
                        resid_out <= resid_in;
                        to_dev_q  <= load_to_dev;
                        tc        <= 1'b0;
                        irq       <= 1'b0;
                        int_code  <= '0;
                    end
                end
                ST_CMD_GRANT: begin
                    remaining <= '0;
                    resid_out <= '0;
                end
                ST_WAIT_DATA: begin
                    if (avail_valid) begin
                        remaining <= step_rem;
                        resid_out <= step_resid;
                    end
                end
                ST_DEFER: ;
                ST_FINISH: begin
                    tc       <= 1'b1;
                    irq      <= 1'b1;
                    int_code <= INT_BUS_SERVICE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xfer_len_ctrl_chk.sv
module xfer_len_ctrl_chk #(
    parameter int BYTE_W  = 8,
    parameter int RES_W   = 18,
    parameter int AVL_W   = 17,
    parameter int CMD_CAP = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    cmd_phase,
    input logic [BYTE_W-1:0]       cnt_lo,
    input logic [BYTE_W-1:0]       cnt_mid,
    input logic signed [RES_W-1:0] resid_in,
    input logic                    avail_valid,
    input logic [AVL_W-1:0]        avail_len,
    input logic                    busy,
    input logic                    chunk_valid,
    input logic [2*BYTE_W:0]       chunk_len,
    input logic [2*BYTE_W:0]       remaining,
    input logic signed [RES_W-1:0] resid_out,
    input logic                    tc,
    input logic                    done,
    input logic                    irq,
    input logic [7:0]              int_code
);
    localparam int LEN_W = 2 * BYTE_W + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = {1'b1, {(LEN_W-1){1'b0}}};

    assert_len_limit_R1: assert property (@(posedge clk) disable iff (rst)
        remaining <= LEN_MAX);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy && !tc && !irq);

    assert_chunk_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |-> chunk_len <= remaining);

    assert_chunk_deducts_R5: assert property (@(posedge clk) disable iff (rst)
        chunk_valid |=> remaining == $past(remaining) - $past(chunk_len));

    assert_starved_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy && !chunk_valid && !done && !avail_valid |=>
        $stable(remaining) && $stable(resid_out));

    assert_done_status_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> tc && irq && int_code == 8'h10 && !busy);

    assert_done_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind xfer_len_ctrl xfer_len_ctrl_chk #(
    .BYTE_W (BYTE_W),
    .RES_W  (RES_W),
    .AVL_W  (AVL_W),
    .CMD_CAP(CMD_CAP)
) u_chk (.*);

// File: tb/xfer_len_ctrl_bench.sv
`timescale 1ns/1ps
module xfer_len_ctrl_bench;
    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic               cmd_phase;
    logic [7:0]         cnt_lo;
    logic [7:0]         cnt_mid;
    logic signed [17:0] resid_in;
    logic               avail_valid;
    logic [16:0]        avail_len;
    logic               busy;
    logic               chunk_valid;
    logic [16:0]        chunk_len;
    logic [16:0]        remaining;
    logic signed [17:0] resid_out;
    logic               tc;
    logic               done;
    logic               irq;
    logic [7:0]         int_code;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xfer_len_ctrl u_xfer_len_ctrl (
        .clk(clk), .rst(rst), .start(start), .cmd_phase(cmd_phase),
        .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .resid_in(resid_in),
        .avail_valid(avail_valid), .avail_len(avail_len),
        .busy(busy), .chunk_valid(chunk_valid), .chunk_len(chunk_len),
        .remaining(remaining), .resid_out(resid_out), .tc(tc),
        .done(done), .irq(irq), .int_code(int_code)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic begin_xfer(input logic [7:0] lo, input logic [7:0] mid,
                              input bit cmd, input int res);
        cnt_lo = lo; cnt_mid = mid; cmd_phase = cmd; resid_in = 18'(res);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // offer one buffer; returns the granted chunk seen combinationally
    task automatic offer(input int len, output int cv, output int cl);
        avail_valid = 1'b1; avail_len = 17'(len);
        #1;
        cv = int'(chunk_valid); cl = int'(chunk_len);
        @(negedge clk);
        avail_valid = 1'b0;
    endtask

    task automatic expect_finish(input string req);
        check(req, "done strobe", int'(done), 1);
        @(negedge clk);
        check("R9", "done cleared", int'(done), 0);
        check("R9", "tc set", int'(tc), 1);
        check("R9", "irq set", int'(irq), 1);
        check("R9", "int_code", int'(int_code), 16);
        check("R9", "busy low", int'(busy), 0);
    endtask

    task automatic t_reset;
        check("R10", "busy", int'(busy), 0);
        check("R10", "remaining", int'(remaining), 0);
        check("R10", "resid", int'(resid_out), 0);
        check("R10", "tc", int'(tc), 0);
        check("R10", "irq", int'(irq), 0);
        check("R10", "int_code", int'(int_code), 0);
        check("R10", "done", int'(done), 0);
    endtask

    task automatic t_cmd_zero_count;
        begin_xfer(8'h00, 8'h00, 1'b1, 77);
        check("R2", "cmd length capped", int'(remaining), 32);
        check("R2", "chunk valid", int'(chunk_valid), 1);
        check("R2", "chunk len", int'(chunk_len), 32);
        @(negedge clk);
        check("R2", "remaining after grant", int'(remaining), 0);
        check("R2", "residual zeroed", int'(resid_out), 0);
        expect_finish("R2");
    endtask

    task automatic t_cmd_small;
        begin_xfer(8'h05, 8'h00, 1'b1, 0);
        check("R2", "small cmd count kept", int'(remaining), 5);
        check("R4", "tc cleared by start", int'(tc), 0);
        check("R4", "irq cleared by start", int'(irq), 0);
        check("R4", "int_code cleared", int'(int_code), 0);
        @(negedge clk);
        expect_finish("R2");
    endtask

    task automatic t_read_partial;
        int cv, cl;
        begin_xfer(8'h40, 8'h00, 1'b0, 100);
        check("R3", "count below residual", int'(remaining), 64);
        offer(200, cv, cl);
        check("R5", "chunk valid", cv, 1);
        check("R5", "chunk limited by remaining", cl, 64);
        check("R5", "residual falls from device", int'(resid_out), 36);
        expect_finish("R6");
    endtask

    task automatic t_read_multi;
        int cv, cl;
        begin_xfer(8'h00, 8'h01, 1'b0, 300);
        check("R1", "count from both bytes", int'(remaining), 256);
        offer(100, cv, cl);
        check("R5", "chunk limited by buffer", cl, 100);
        check("R5", "remaining after chunk", int'(remaining), 156);
        check("R5", "residual after chunk", int'(resid_out), 200);
        check("R7", "no done mid transfer", int'(done), 0);
        // start while busy must be ignored
        cnt_lo = 8'h07; cnt_mid = 8'h00; cmd_phase = 1'b1; resid_in = 18'sd5;
        start = 1'b1;
        #1;
        check("R8", "no chunk while starved", int'(chunk_valid), 0);
        @(negedge clk);
        start = 1'b0;
        check("R4", "busy start ignored remaining", int'(remaining), 156);
        check("R4", "busy start ignored resid", int'(resid_out), 200);
        repeat (3) @(negedge clk);
        check("R8", "remaining held", int'(remaining), 156);
        check("R8", "residual held", int'(resid_out), 200);
        offer(156, cv, cl);
        check("R5", "second chunk", cl, 156);
        check("R7", "resid positive", int'(resid_out), 44);
        expect_finish("R7");
    endtask

    task automatic t_read_defer;
        int cv, cl;
        begin_xfer(8'h00, 8'h00, 1'b0, 50);
        check("R3", "residual below count", int'(remaining), 50);
        offer(50, cv, cl);
        check("R7", "exhausted residual zero", int'(resid_out), 0);
        check("R7", "read deferred", int'(done), 0);
        repeat (2) @(negedge clk);
        check("R7", "still deferred", int'(done), 0);
        check("R8", "no chunk while deferred", int'(chunk_valid), 0);
        offer(1, cv, cl);
        check("R7", "no chunk on release", cv, 0);
        expect_finish("R7");
    endtask

    task automatic t_write_defer;
        int cv, cl;
        begin_xfer(8'h34, 8'h12, 1'b0, -40);
        check("R3", "negative residual magnitude", int'(remaining), 40);
        offer(40, cv, cl);
        check("R5", "write chunk", cl, 40);
        check("R5", "residual rises toward device", int'(resid_out), 0);
        check("R7", "write deferred", int'(done), 0);
        @(negedge clk);
        offer(9, cv, cl);
        expect_finish("R7");
    endtask

    task automatic t_write_partial;
        int cv, cl;
        begin_xfer(8'h03, 8'h00, 1'b0, -10);
        check("R3", "count below magnitude", int'(remaining), 3);
        offer(8, cv, cl);
        check("R5", "write partial chunk", cl, 3);
        check("R5", "residual toward device", int'(resid_out), -7);
        expect_finish("R6");
    endtask

    task automatic t_max_count;
        int cv, cl;
        begin_xfer(8'hff, 8'hff, 1'b0, 70000);
        check("R1", "max count", int'(remaining), 65535);
        offer(65535, cv, cl);
        check("R5", "max chunk", cl, 65535);
        check("R7", "resid after max", int'(resid_out), 4465);
        expect_finish("R7");
    endtask

    task automatic t_zero_count_data;
        int cv, cl;
        begin_xfer(8'h00, 8'h00, 1'b0, 100000);
        check("R1", "zero count means 65536", int'(remaining), 65536);
        offer(65536, cv, cl);
        check("R5", "full chunk", cl, 65536);
        check("R7", "resid after full", int'(resid_out), 34464);
        expect_finish("R7");
    endtask

    task automatic t_zero_residual;
        int cv, cl;
        begin_xfer(8'h10, 8'h00, 1'b0, 0);
        check("R3", "zero residual clamps to zero", int'(remaining), 0);
        offer(4, cv, cl);
        check("R5", "empty chunk", cl, 0);
        expect_finish("R6");
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; cmd_phase = 1'b0; cnt_lo = '0; cnt_mid = '0;
        resid_in = '0; avail_valid = 1'b0; avail_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmd_zero_count();
        t_cmd_small();
        t_read_partial();
        t_read_multi();
        t_read_defer();
        t_write_defer();
        t_write_partial();
        t_max_count();
        t_zero_count_data();
        t_zero_residual();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule